// File: doc/BRIEF.md
# Function Result Reuse Table

This block remembers the results of side-effect-free function calls so that a processor can skip a call whose answer it already knows. When the decoder sees a call instruction, it presents the callee's identifier, the number of arguments in use and up to two 32-bit argument values on the lookup port. One clock later the block reports whether an earlier call with exactly the same function and the same inputs left its result in the table. On a hit it also returns that stored result, and the pipeline can bypass the whole function body.

On a miss the call runs normally. When it returns, the update port writes the function identifier, the arguments and the returned value into the table. The table is direct-mapped. The slot is chosen by folding an exclusive-or of the key fields down to the index width, and the full key is compared on every lookup. A purity bit comes with every lookup and every update. Only calls marked pure are looked up or stored, because deciding which functions are pure is done outside this block. A flush input empties the table in one cycle.

Top module: `fn_reuse_table`

## Requirements
- R1: After reset every entry is invalid: `lk_hit` and `lk_result` are 0, and any lookup misses.
- R2: A lookup whose key (function id, argument count, arguments in use) equals the key of the valid entry at its index gives `lk_hit`=1 and that entry's result on `lk_result` in the following cycle.
- R3: A lookup that misses gives `lk_hit`=0 and `lk_result`=0 in the following cycle. A cycle without a lookup also gives `lk_hit`=0 and `lk_result`=0 in the following cycle.
- R4: The index is computed as follows. First h = fid ^ a0 ^ {a1[15:0],a1[31:16]} ^ argc, where fid and argc are zero-extended to 32 bits and a0 and a1 are the masked arguments. Index bit b is then the XOR of all bits j of h with j mod IDX_W == b, where IDX_W = log2(DEPTH).
- R5: Arguments not in use are masked to zero before hashing and comparing. With argc=0 both arguments are masked; with argc=1 only arg1 is masked. Changing a masked argument therefore does not change a hit.
- R6: A lookup or an update with the purity bit at 0, or with argc=3, has no effect. Such a lookup never hits, and such an update writes nothing.
- R7: An accepted update writes its key and result to its index and replaces whatever entry was there, so a different key that hashed to the same index then misses.
- R8: When a lookup and an update reach the same index in the same cycle, the lookup sees the contents from before the update. The update is visible to a lookup in the next cycle.
- R9: Flush invalidates every entry at the clock edge. A lookup in the flush cycle still sees the old contents. An update in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request (call decoded) |
| lk_pure | input | 1 | Callee is marked free of side effects |
| lk_fid | input | FID_W | Callee identifier |
| lk_argc | input | 2 | Number of arguments in use (0 to 2) |
| lk_arg0 | input | 32 | First argument |
| lk_arg1 | input | 32 | Second argument |
| lk_hit | output | 1 | Registered hit, one cycle after the lookup |
| lk_result | output | 32 | Stored result on a hit, else 0 |
| up_valid | input | 1 | Update request (call returned) |
| up_pure | input | 1 | Callee is marked free of side effects |
| up_fid | input | FID_W | Callee identifier |
| up_argc | input | 2 | Number of arguments in use |
| up_arg0 | input | 32 | First argument |
| up_arg1 | input | 32 | Second argument |
| up_result | input | 32 | Value the call returned |

## Verification
A wrong stored key, a bad index fold or a lost valid bit shows up at the ports as a wrong `lk_hit` or `lk_result` one cycle after the lookup that reads the damaged slot. A missing overwrite or a flush that leaves entries behind shows up as a stale hit, at the first later lookup of the old key. A purity or argument-count gate that leaks shows up as a hit on a key that should never have been stored. The bench keeps its own model of the table and compares every lookup cycle, so such a fault appears the first time random traffic touches the affected slot.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int ARG_W    = 32;
  localparam int RES_W    = 32;
  localparam int KFID_W   = 32;
  localparam int ARGC_W   = 2;
  localparam int MAX_ARGC = 2;

  typedef struct packed {
    logic [KFID_W-1:0] fid;
    logic [ARGC_W-1:0] argc;
    logic [ARG_W-1:0]  a0;
    logic [ARG_W-1:0]  a1;
  } frt_key_t;

  // Build a key with unused arguments forced to zero.
  function automatic frt_key_t make_key(input logic [KFID_W-1:0] fid,
                                        input logic [ARGC_W-1:0] argc,
                                        input logic [ARG_W-1:0]  a0,
                                        input logic [ARG_W-1:0]  a1);
    frt_key_t k;
    k.fid  = fid;
    k.argc = argc;
    k.a0   = (argc >= 2'd1) ? a0 : '0;
    k.a1   = (argc >= 2'd2) ? a1 : '0;
    return k;
  endfunction

  // 32-bit mix of the key fields before folding to the index width.
  function automatic logic [31:0] mix32(input frt_key_t k);
    return k.fid ^ k.a0 ^ {k.a1[15:0], k.a1[31:16]} ^ {30'd0, k.argc};
  endfunction
endpackage

// File: rtl/frt_hash.sv
module frt_hash
  import frt_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  frt_key_t           key,
  output logic [IDX_W-1:0]   idx
);
  localparam int CHUNKS = (32 + IDX_W - 1) / IDX_W;

  logic [31:0] h;
  assign h = mix32(key);

  always_comb begin
    idx = '0;
    for (int i = 0; i < CHUNKS; i++)
      idx = idx ^ IDX_W'(h >> (i * IDX_W));
  end
endmodule

// File: rtl/frt_store.sv
module frt_store
  import frt_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  frt_key_t         wr_key,
  input  logic [RES_W-1:0] wr_res,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output frt_key_t         rd_key,
  output logic [RES_W-1:0] rd_res
);
  logic [DEPTH-1:0] valid_q;
  frt_key_t         key_q [DEPTH];
  logic [RES_W-1:0] res_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)      valid_q <= '0;
    else if (flush)  valid_q <= '0;
    else if (wr_en)  valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      key_q[wr_idx] <= wr_key;
      res_q[wr_idx] <= wr_res;
    end
  end

  // Read sees the pre-edge contents: lookup-before-update ordering.
  assign rd_valid = valid_q[rd_idx];
  assign rd_key   = key_q[rd_idx];
  assign rd_res   = res_q[rd_idx];
endmodule

// File: rtl/frt_match.sv
module frt_match
  import frt_pkg::*;
(
  input  logic     probe_en,
  input  frt_key_t probe_key,
  input  logic     ent_valid,
  input  frt_key_t ent_key,
  output logic     hit
);
  assign hit = probe_en && ent_valid && (probe_key == ent_key);
endmodule

// File: rtl/fn_reuse_table.sv
module fn_reuse_table
  import frt_pkg::*;
#(
  parameter int FID_W = 16,
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic              lk_pure,
  input  logic [FID_W-1:0]  lk_fid,
  input  logic [1:0]        lk_argc,
  input  logic [31:0]       lk_arg0,
  input  logic [31:0]       lk_arg1,
  output logic              lk_hit,
  output logic [31:0]       lk_result,
  input  logic              up_valid,
  input  logic              up_pure,
  input  logic [FID_W-1:0]  up_fid,
  input  logic [1:0]        up_argc,
  input  logic [31:0]       up_arg0,
  input  logic [31:0]       up_arg1,
  input  logic [31:0]       up_result
);
  localparam int IDX_W = $clog2(DEPTH);

  // Named internal events
  logic             lk_elig, up_accept, hit_now;
  frt_key_t         lk_key, up_key, rd_key;
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             rd_valid;
  logic [RES_W-1:0] rd_res;

  assign lk_elig   = lk_valid && lk_pure && (lk_argc <= 2'(MAX_ARGC));
  assign up_accept = up_valid && up_pure && (up_argc <= 2'(MAX_ARGC)) && !flush;
  assign lk_key    = make_key(KFID_W'(lk_fid), lk_argc, lk_arg0, lk_arg1);
  assign up_key    = make_key(KFID_W'(up_fid), up_argc, up_arg0, up_arg1);

  frt_hash #(.IDX_W(IDX_W)) u_lk_hash (.key(lk_key), .idx(lk_idx));
  frt_hash #(.IDX_W(IDX_W)) u_up_hash (.key(up_key), .idx(up_idx));

  frt_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (up_accept),
    .wr_idx   (up_idx),
    .wr_key   (up_key),
    .wr_res   (up_result),
    .rd_idx   (lk_idx),
    .rd_valid (rd_valid),
    .rd_key   (rd_key),
    .rd_res   (rd_res)
  );

  frt_match u_match (
    .probe_en  (lk_elig),
    .probe_key (lk_key),
    .ent_valid (rd_valid),
    .ent_key   (rd_key),
    .hit       (hit_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit    <= 1'b0;
      lk_result <= '0;
    end else begin
      lk_hit    <= hit_now;
      lk_result <= hit_now ? rd_res : '0;
    end
  end
endmodule

// File: rtl/fn_reuse_table_chk.sv
module fn_reuse_table_chk
  import frt_pkg::*;
#(
  parameter int FID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic             lk_pure,
  input logic [FID_W-1:0] lk_fid,
  input logic [1:0]       lk_argc,
  input logic [31:0]      lk_arg0,
  input logic [31:0]      lk_arg1,
  input logic             lk_hit,
  input logic [31:0]      lk_result,
  input logic             up_valid,
  input logic             up_pure,
  input logic [FID_W-1:0] up_fid,
  input logic [1:0]       up_argc,
  input logic [31:0]      up_arg0,
  input logic [31:0]      up_arg1,
  input logic [31:0]      up_result
);
  logic     up_ok, empty_q, last_ok;
  frt_key_t last_key;
  logic [31:0] last_res;

  assign up_ok = up_valid && up_pure && (up_argc <= 2'd2) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q  <= 1'b1;
      last_ok  <= 1'b0;
      last_key <= '0;
      last_res <= '0;
    end else begin
      if (flush)      empty_q <= 1'b1;
      else if (up_ok) empty_q <= 1'b0;
      last_ok  <= up_ok;
      last_key <= make_key(32'(up_fid), up_argc, up_arg0, up_arg1);
      last_res <= up_result;
    end
  end

  a_r3_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));

  a_r3_miss_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_result == 32'd0));

  a_r6_ineligible_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (!lk_pure || lk_argc == 2'd3)) |=> !lk_hit);

  a_r9_empty_table_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !$past(empty_q));

  a_r2_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_pure && last_ok &&
     make_key(32'(lk_fid), lk_argc, lk_arg0, lk_arg1) == last_key)
    |=> (lk_hit && lk_result == $past(last_res)));
endmodule

bind fn_reuse_table fn_reuse_table_chk #(.FID_W(FID_W)) u_chk (.*);

// File: tb/fn_reuse_table_test.sv
module fn_reuse_table_test;
  localparam int FID_W = 16;
  localparam int DEPTH = 128;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, flush = 0;
  logic lk_valid = 0, lk_pure = 0, up_valid = 0, up_pure = 0;
  logic [FID_W-1:0] lk_fid = 0, up_fid = 0;
  logic [1:0]  lk_argc = 0, up_argc = 0;
  logic [31:0] lk_arg0 = 0, lk_arg1 = 0, up_arg0 = 0, up_arg1 = 0, up_result = 0;
  logic        lk_hit;
  logic [31:0] lk_result;

  int checks = 0, fails = 0;
  bit done = 0;

  // model
  bit          mvalid [DEPTH];
  logic [97:0] mkey   [DEPTH];
  logic [31:0] mres   [DEPTH];

  always #4 clk = ~clk;

  fn_reuse_table #(.FID_W(FID_W), .DEPTH(DEPTH)) uut (.*);

  function automatic logic [97:0] bkey(input logic [FID_W-1:0] f, input logic [1:0] c,
                                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] am = (c == 2'd0) ? 32'd0 : a;
    logic [31:0] bm = (c == 2'd0 || c == 2'd1) ? 32'd0 : b;
    return {32'(f), c, am, bm};
  endfunction

  // bitwise restatement of the index fold (R4)
  function automatic logic [IDX_W-1:0] bidx(input logic [97:0] k);
    logic [31:0] f = k[97:66];
    logic [31:0] a = k[63:32];
    logic [31:0] b = k[31:0];
    logic [31:0] h = f ^ a ^ {b[15:0], b[31:16]} ^ {30'd0, k[65:64]};
    logic [IDX_W-1:0] r = '0;
    for (int j = 0; j < 32; j++) r[j % IDX_W] = r[j % IDX_W] ^ h[j];
    return r;
  endfunction

  task automatic check(input string tag, input logic ah, input logic [31:0] ar,
                       input logic eh, input logic [31:0] er);
    checks++;
    if (ah !== eh || ar !== er) begin
      fails++;
      $display("FAIL %s: hit=%0d result=%h expected hit=%0d result=%h", tag, ah, ar, eh, er);
    end
  endtask

  // One clock: expectation from model, edge, model update, check.
  task automatic tick(input string tag);
    logic eh = 0;
    logic [31:0] er = 0;
    logic [97:0] lk, uk;
    lk = bkey(lk_fid, lk_argc, lk_arg0, lk_arg1);
    uk = bkey(up_fid, up_argc, up_arg0, up_arg1);
    if (lk_valid && lk_pure && lk_argc != 2'd3) begin
      int i = int'(bidx(lk));
      if (mvalid[i] && mkey[i] == lk) begin eh = 1; er = mres[i]; end
    end
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) mvalid[i] = 0;
    end else if (up_valid && up_pure && up_argc != 2'd3) begin
      int i = int'(bidx(uk));
      mvalid[i] = 1; mkey[i] = uk; mres[i] = up_result;
    end
    @(negedge clk);
    check(tag, lk_hit, lk_result, eh, er);
  endtask

  task automatic set_lk(input logic v, input logic p, input logic [FID_W-1:0] f,
                        input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    lk_valid = v; lk_pure = p; lk_fid = f; lk_argc = c; lk_arg0 = a; lk_arg1 = b;
  endtask

  task automatic set_up(input logic v, input logic p, input logic [FID_W-1:0] f,
                        input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] r);
    up_valid = v; up_pure = p; up_fid = f; up_argc = c; up_arg0 = a; up_arg1 = b; up_result = r;
  endtask

  task automatic idle();
    set_lk(0, 0, 0, 0, 0, 0); set_up(0, 0, 0, 0, 0, 0, 0); flush = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] cola;
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    for (int i = 0; i < DEPTH; i++) mvalid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1 reset outputs", lk_hit, lk_result, 0, 0);
    set_lk(1, 1, 16'h0005, 2'd2, 32'd7, 32'd9);
    tick("R1 lookup after reset misses");

    // R2: write then hit
    idle(); set_up(1, 1, 16'h0005, 2'd2, 32'd7, 32'd9, 32'h1234_5678);
    tick("R3 idle cycle");
    idle(); set_lk(1, 1, 16'h0005, 2'd2, 32'd7, 32'd9);
    tick("R2 hit after update");
    if (lk_hit !== 1'b1 || lk_result !== 32'h1234_5678)
      check("R2 directed value", lk_hit, lk_result, 1, 32'h1234_5678);

    // R5: masked arguments
    idle(); set_up(1, 1, 16'h0011, 2'd1, 32'd3, 32'hAAAA_0000, 32'd55);
    tick("R5 setup");
    idle(); set_lk(1, 1, 16'h0011, 2'd1, 32'd3, 32'h0000_BBBB);
    tick("R5 arg1 ignored with argc=1");
    check("R5 directed", lk_hit, lk_result, 1, 32'd55);
    idle(); set_up(1, 1, 16'h0012, 2'd0, 32'd1, 32'd2, 32'd77);
    tick("R5 setup argc0");
    idle(); set_lk(1, 1, 16'h0012, 2'd0, 32'hFFFF, 32'hEEEE);
    tick("R5 both args ignored with argc=0");
    check("R5 directed argc0", lk_hit, lk_result, 1, 32'd77);

    // R4/R7: collision overwrite
    cola = 0;
    for (int a = 1; a < 100000; a++) begin
      if (bidx(bkey(16'h0005, 2'd1, 32'(a), 0)) == bidx(bkey(16'h0005, 2'd2, 32'd7, 32'd9))) begin
        cola = 32'(a); break;
      end
    end
    idle(); set_up(1, 1, 16'h0005, 2'd1, cola, 32'd0, 32'hC0FF_EE00);
    tick("R4 collision write");
    idle(); set_lk(1, 1, 16'h0005, 2'd2, 32'd7, 32'd9);
    tick("R7 overwritten key misses");
    check("R7 directed", lk_hit, lk_result, 0, 0);
    idle(); set_lk(1, 1, 16'h0005, 2'd1, cola, 32'd0);
    tick("R4 colliding key hits");
    check("R4 directed", lk_hit, lk_result, 1, 32'hC0FF_EE00);

    // R6: ineligible
    idle(); set_up(1, 0, 16'h0021, 2'd1, 32'd4, 0, 32'd9);
    tick("R6 impure update");
    idle(); set_up(1, 1, 16'h0022, 2'd3, 32'd4, 32'd4, 32'd9);
    set_lk(1, 1, 16'h0021, 2'd1, 32'd4, 0);
    tick("R6 impure update not stored");
    check("R6 directed", lk_hit, lk_result, 0, 0);
    idle(); set_lk(1, 1, 16'h0022, 2'd3, 32'd4, 32'd4);
    tick("R6 argc3 never hits");
    idle(); set_lk(1, 0, 16'h0005, 2'd1, cola, 0);
    tick("R6 impure lookup misses");
    check("R6 impure lookup directed", lk_hit, lk_result, 0, 0);

    // R8: same-cycle lookup and update
    idle(); set_lk(1, 1, 16'h0005, 2'd1, cola, 0);
    set_up(1, 1, 16'h0005, 2'd1, cola, 0, 32'hDEAD_0001);
    tick("R8 lookup sees old contents");
    check("R8 old value", lk_hit, lk_result, 1, 32'hC0FF_EE00);
    idle(); set_lk(1, 1, 16'h0005, 2'd1, cola, 0);
    tick("R8 update visible next cycle");
    check("R8 new value", lk_hit, lk_result, 1, 32'hDEAD_0001);

    // R9: flush
    idle(); flush = 1; set_lk(1, 1, 16'h0005, 2'd1, cola, 0);
    set_up(1, 1, 16'h0031, 2'd1, 32'd8, 0, 32'd5);
    tick("R9 lookup in flush cycle sees old");
    check("R9 flush-cycle hit", lk_hit, lk_result, 1, 32'hDEAD_0001);
    idle(); set_lk(1, 1, 16'h0005, 2'd1, cola, 0);
    tick("R9 entry gone after flush");
    idle(); set_lk(1, 1, 16'h0031, 2'd1, 32'd8, 0);
    tick("R9 update dropped during flush");
    check("R9 directed", lk_hit, lk_result, 0, 0);

    // Random traffic: R2 R3 R5 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      set_lk($urandom_range(0, 3) != 0, $urandom_range(0, 9) != 0, 16'($urandom_range(0, 7)),
             2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 3));
      set_up($urandom_range(0, 1) == 1, $urandom_range(0, 9) != 0, 16'($urandom_range(0, 7)),
             2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 3), $urandom);
      flush = ($urandom_range(0, 199) == 0);
      tick("R2/R3 random traffic");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule